// File: doc/BRIEF.md
# Modem Control and Status Register Pair with Loopback

This block holds the modem control byte of a 16550-style serial port and produces the matching modem status byte. Software writes the control byte through a write strobe. The upper nibble of the status byte shows the current state of four status lines. The lower nibble holds sticky change flags, which are cleared when the status byte is read.

Control bit 4 selects loopback. With loopback set, the four control outputs drive the four status lines. With loopback clear, the status lines are fixed: carrier-detect and data-set-ready read as asserted, and clear-to-send and ring read as deasserted. Every control write compares the new status lines with the old ones and sets the matching change flags. A pending output tells the interrupt logic that at least one change flag is set.

Top module: `modem_ctl_status`

## Requirements
- R1: A control write stores only data bits 4:0. Bits 7:5 of the stored control byte always read as zero, whatever the write data held in those positions. Control bit 0 is DTR, bit 1 is RTS, bit 2 is OUT1, bit 3 is OUT2 and bit 4 is loopback.
- R2: With loopback set, the status upper nibble follows the control bits as follows: bit 4 (CTS) takes RTS, bit 5 (DSR) takes DTR, bit 6 (RI) takes OUT1 and bit 7 (DCD) takes OUT2.
- R3: With loopback clear, the status upper nibble reads 4'b1010: DCD and DSR are high, RI and CTS are low.
- R4: On a control write, a change in CTS sets status bit 0, a change in DSR sets bit 1, and a change in DCD sets bit 3.
- R5: Status bit 2 is set only when a control write takes RI from 1 to 0. A rise of RI from 0 to 1 leaves bit 2 unchanged.
- R6: Change flags that are already set stay set across later writes and idle cycles until the status byte is read.
- R7: After reset the control byte is 0x00 and the status byte is 0xA0, with no change flags set.
- R8: Reading the status byte returns the value it held during the read cycle. After that clock edge, bits 3:0 are zero unless a same-cycle write sets them.
- R9: When a read and a write fall in the same cycle, the flags set by that write survive and the older flags are cleared.
- R10: The pending output is high exactly when any of status bits 3:0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| sts_rd | input | 1 | Status byte read strobe (clears change flags) |
| ctl_q | output | 8 | Stored control byte |
| sts_q | output | 8 | Status byte: line states in 7:4, change flags in 3:0 |
| delta_pend | output | 1 | High while any change flag is set |

## Verification
A control write and a status read can fall in the same clock cycle. The read then clears the old change flags while the write sets new ones. The bench provokes this by asserting both strobes together, with the write dropping RI from 1 to 0 while the ring flag is already set from earlier writes. It then judges two things: the read must return the byte as it stood before that edge, and the next status byte must hold only the flag that the write produced.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int BYTE_W  = 8;
    localparam int CTL_W   = 5;
    localparam int LINE_W  = 4;
    localparam int FLAG_W  = 4;
    localparam int PAD_W   = BYTE_W - CTL_W;

    // control byte, MSB first: loopback, out2, out1, rts, dtr
    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } ctl_t;

    // status line nibble, MSB first: dcd, ri, dsr, cts
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } lines_t;

    // change flags, MSB first: dcd change, ri trailing edge, dsr change, cts change
    typedef struct packed {
        logic d_dcd;
        logic t_ri;
        logic d_dsr;
        logic d_cts;
    } flags_t;

    localparam lines_t IDLE_LINES = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b0};

    function automatic lines_t derive_lines(input ctl_t c);
        lines_t l;
        if (c.loop) begin
            l.cts = c.rts;
            l.dsr = c.dtr;
            l.ri  = c.out1;
            l.dcd = c.out2;
        end else begin
            l = IDLE_LINES;
        end
        return l;
    endfunction

    function automatic flags_t edge_flags(input lines_t was, input lines_t now);
        flags_t f;
        f.d_cts = was.cts ^ now.cts;
        f.d_dsr = was.dsr ^ now.dsr;
        f.d_dcd = was.dcd ^ now.dcd;
        f.t_ri  = was.ri & ~now.ri;
        return f;
    endfunction

endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output ctl_t              ctl,
    output ctl_t              ctl_next
);
    ctl_t ctl_r;

    always_comb begin
        ctl_next = wr ? ctl_t'(wdata[CTL_W-1:0]) : ctl_r;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_r <= '0;
        else     ctl_r <= ctl_next;
    end

    assign ctl = ctl_r;

    a_r1_masked_store: assert property (@(posedge clk) disable iff (rst)
        wr |=> (ctl_r == ctl_t'($past(wdata[CTL_W-1:0]))));

    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(ctl_r));

endmodule

// File: rtl/mdm_status.sv
module mdm_status
    import mdm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr,
    input  logic   rd,
    input  ctl_t   ctl_next,
    output lines_t lines,
    output flags_t flags
);
    lines_t lines_r;
    flags_t flags_r;
    lines_t lines_new;
    flags_t set_now;
    flags_t flags_kept;

    always_comb begin
        lines_new  = derive_lines(ctl_next);
        set_now    = wr ? edge_flags(lines_r, lines_new) : '0;
        flags_kept = rd ? '0 : flags_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lines_r <= IDLE_LINES;
            flags_r <= '0;
        end else begin
            if (wr) lines_r <= lines_new;
            flags_r <= flags_kept | set_now;
        end
    end

    assign lines = lines_r;
    assign flags = flags_r;

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        !rd && !wr |=> $stable(flags_r));

    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        rd && !wr |=> (flags_r == '0));

    a_r5_trailing_ri: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_r.t_ri) |-> ($past(wr) && $past(lines_r.ri) && !lines_r.ri));

    a_r9_new_flags_survive: assert property (@(posedge clk) disable iff (rst)
        (rd && wr && (lines_r.cts != lines_new.cts)) |=> flags_r.d_cts);

endmodule

// File: rtl/modem_ctl_status.sv
module modem_ctl_status
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [BYTE_W-1:0] ctl_wdata,
    input  logic              sts_rd,
    output logic [BYTE_W-1:0] ctl_q,
    output logic [BYTE_W-1:0] sts_q,
    output logic              delta_pend
);
    ctl_t   ctl_cur;
    ctl_t   ctl_nxt;
    lines_t lines;
    flags_t flags;

    mdm_ctl_reg u_ctl (
        .clk      (clk),
        .rst      (rst),
        .wr       (ctl_wr),
        .wdata    (ctl_wdata),
        .ctl      (ctl_cur),
        .ctl_next (ctl_nxt)
    );

    mdm_status u_sts (
        .clk      (clk),
        .rst      (rst),
        .wr       (ctl_wr),
        .rd       (sts_rd),
        .ctl_next (ctl_nxt),
        .lines    (lines),
        .flags    (flags)
    );

    assign ctl_q      = {{PAD_W{1'b0}}, ctl_cur};
    assign sts_q      = {lines, flags};
    assign delta_pend = |flags;

    a_r2_loop_map: assert property (@(posedge clk) disable iff (rst)
        ctl_cur.loop |-> (lines.cts == ctl_cur.rts && lines.dsr == ctl_cur.dtr &&
                          lines.ri == ctl_cur.out1 && lines.dcd == ctl_cur.out2));

    a_r3_idle_lines: assert property (@(posedge clk) disable iff (rst)
        !ctl_cur.loop |-> (sts_q[7:4] == 4'b1010));

    a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
        ctl_q[7:5] == 3'b000);

endmodule

// File: tb/modem_ctl_status_test.sv
module modem_ctl_status_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       sts_rd = 1'b0;
    logic [7:0] ctl_q;
    logic [7:0] sts_q;
    logic       delta_pend;

    always #2 clk = ~clk;

    modem_ctl_status uut (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .sts_rd     (sts_rd),
        .ctl_q      (ctl_q),
        .sts_q      (sts_q),
        .delta_pend (delta_pend)
    );

    int n_chk = 0;
    int n_bad = 0;

    // bench-side model
    logic [4:0] m_ctl   = '0;
    logic [3:0] m_lines = 4'b1010;
    logic [3:0] m_flags = '0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    function automatic logic [3:0] lines_of(input logic [4:0] c);
        // {dcd, ri, dsr, cts}
        if (c[4]) return {c[3], c[2], c[0], c[1]};
        return 4'b1010;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic op(input logic wr, input logic [7:0] wd, input logic rd, input string tag);
        logic [3:0] nl;
        logic [3:0] setf;
        @(negedge clk);
        ctl_wr    = wr;
        ctl_wdata = wd;
        sts_rd    = rd;
        if (rd) begin
            exp_q.push_back({m_lines, m_flags});
            tag_q.push_back(tag);
        end
        setf = '0;
        if (wr) begin
            nl   = lines_of(wd[4:0]);
            setf[0] = nl[0] ^ m_lines[0];
            setf[1] = nl[1] ^ m_lines[1];
            setf[3] = nl[3] ^ m_lines[3];
            setf[2] = m_lines[2] & ~nl[2];
            m_ctl   = wd[4:0];
            m_lines = nl;
        end
        m_flags = (rd ? 4'b0 : m_flags) | setf;
    endtask

    task automatic peek(input string tag);
        @(negedge clk);
        ctl_wr = 1'b0;
        sts_rd = 1'b0;
        #1;
        check({tag, " ctl"}, ctl_q, {3'b000, m_ctl});
        check({tag, " sts"}, sts_q, {m_lines, m_flags});
        check({tag, " pend"}, {7'b0, delta_pend}, {7'b0, |m_flags});
    endtask

    // monitor: compares the byte seen during each read cycle
    always @(negedge clk) begin
        #1;
        if (sts_rd && exp_q.size() > 0) begin
            check(tag_q.pop_front(), sts_q, exp_q.pop_front());
        end
    end

    initial begin : watchdog
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        peek("R7 reset");
        op(1'b1, 8'hFF, 1'b0, "");
        peek("R1 R2 R4 loopback all on");
        op(1'b0, 8'h00, 1'b1, "R8 read cts flag");
        peek("R8 R10 cleared after read");
        op(1'b1, 8'h10, 1'b0, "");
        peek("R4 R5 loopback all off");
        op(1'b1, 8'h14, 1'b0, "");
        peek("R5 R6 ri rise keeps flags");
        op(1'b0, 8'h00, 1'b0, "");
        peek("R6 idle keeps flags");
        op(1'b1, 8'h10, 1'b1, "R9 read during write");
        peek("R9 only new ri flag");
        op(1'b1, 8'h00, 1'b0, "");
        peek("R3 R4 leave loopback");
        op(1'b1, 8'hE0, 1'b0, "");
        peek("R1 upper bits ignored");
        op(1'b0, 8'h00, 1'b1, "R8 read flags");
        peek("R8 R10 idle after read");
        op(1'b1, 8'h0B, 1'b0, "");
        peek("R3 lines fixed without loopback");
        op(1'b1, 8'h1A, 1'b0, "");
        peek("R2 partial loopback map");
        op(1'b0, 8'h00, 1'b1, "R8 read partial");
        peek("R10 pend low");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule